// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It divides its input clock by N = B·P + A and marks the end of each division cycle with one output pulse. It does not use a single wide programmable counter. A small prescaler divides by either P or P+1. A swallow counter keeps the prescaler in its P+1 setting for the first A prescaler periods of a cycle. A main counter counts all B prescaler periods and closes the cycle.

The modulus pair is chosen with a 2-bit code. The swallow value A is 6 bits wide and the main value B is 13 bits wide. New settings are taken in only when a cycle starts, so a change made mid-cycle never distorts the period that is in progress. A setting with B smaller than A, or with B equal to zero, cannot be divided correctly. Such a setting is reported on an error output and the divider stays silent until the setting becomes valid.

Top module: `swallow_fbdiv`

## Requirements
- R1: In steady operation with a fixed valid setting, consecutive rising edges of pulse_o are exactly N = B·P + A input clocks apart.
- R2: mode_i selects P: 2'b00 gives 8/9, 2'b01 gives 16/17, 2'b10 gives 32/33 and 2'b11 gives 64/65.
- R3: pulse_o is high for exactly one input clock per division cycle.
- R4: After rst_ni is released, pulse_o first goes high in the clock period that follows the N-th rising clock edge.
- R5: With A = 0 the period is B·P (the prescaler never uses P+1).
- R6: With A = B the period is B·(P+1).
- R7: cfg_err_o is high, directly from the present inputs, whenever main_i < swallow_i or main_i = 0. While it is high, pulse_o stays low.
- R8: When the setting becomes valid again after an error, the cycle restarts from the beginning. The first pulse follows the N-th rising edge counted from the first edge that sees the valid setting.
- R9: A change of swallow_i, main_i or mode_i during a cycle does not alter that cycle's length. The next cycle uses the new value of N.
- R10: While rst_ni is low, pulse_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, released synchronously upstream |
| swallow_i | input | 6 | Swallow count A |
| main_i | input | 13 | Main count B |
| mode_i | input | 2 | Prescaler modulus pair select |
| pulse_o | output | 1 | One-clock pulse once per division cycle |
| cfg_err_o | output | 1 | Present setting is not divisible (B < A or B = 0) |

## Verification
The hardest situations to reach from the ports are a setting change that lands in the middle of a cycle, and recovery from an invalid setting. Both depend on where inside a long cycle the inputs move. The stimulus finds a pulse, waits a fixed number of clocks, and then changes the setting. It then measures the shortened remainder of the old cycle and the full length of the new one. Random settings across all four modulus pairs are mixed with directed cases: A = 0, A = B, B = 1, and the largest B. This covers both the swallow-then-plain ordering and its two degenerate ends.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  parameter int unsigned FB_A_W    = 6;
  parameter int unsigned FB_B_W    = 13;
  parameter int unsigned FB_MODE_W = 2;
  parameter int unsigned FB_BASE_P = 8;

  // Widest prescaler count value needed: largest P (count runs 0..P).
  function automatic int unsigned fb_max_p(int unsigned base_p, int unsigned mode_w);
    return base_p << ((1 << mode_w) - 1);
  endfunction
endpackage

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
  parameter int unsigned MODE_W = fbdiv_pkg::FB_MODE_W,
  parameter int unsigned BASE_P = fbdiv_pkg::FB_BASE_P,
  localparam int unsigned MAX_P = fbdiv_pkg::fb_max_p(BASE_P, MODE_W),
  localparam int unsigned CNT_W = $clog2(MAX_P + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [MODE_W-1:0] mode_ld_i,
  input  logic              plus_one_i,
  output logic              tick_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_eff, ratio, limit;
  logic [MODE_W-1:0] mode_q, mode_d, mode_eff;

  always_comb begin
    mode_eff = restart_i ? mode_ld_i : mode_q;
    cnt_eff  = restart_i ? '0 : cnt_q;
    ratio    = CNT_W'(BASE_P) << mode_eff;
    limit    = ratio - CNT_W'(1) + CNT_W'(plus_one_i);
    tick_o   = (cnt_eff == limit);
    cnt_d    = cnt_q;
    mode_d   = mode_q;
    if (en_i) begin
      cnt_d  = tick_o ? '0 : cnt_eff + CNT_W'(1);
      mode_d = mode_eff;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/fbdiv_downcnt.sv
module fbdiv_downcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         restart_i,
  input  logic [W-1:0] load_i,
  input  logic         dec_i,
  output logic         is_zero_o,
  output logic         is_one_o,
  output logic [W-1:0] value_o
);
  logic [W-1:0] val_q, val_d, val_eff;

  always_comb begin
    val_eff   = restart_i ? load_i : val_q;
    is_zero_o = (val_eff == '0);
    is_one_o  = (val_eff == W'(1));
    val_d     = val_q;
    if (en_i) begin
      val_d = (dec_i && !is_zero_o) ? val_eff - W'(1) : val_eff;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign value_o = val_q;
endmodule

// File: rtl/swallow_fbdiv.sv
module swallow_fbdiv #(
  parameter int unsigned A_W    = fbdiv_pkg::FB_A_W,
  parameter int unsigned B_W    = fbdiv_pkg::FB_B_W,
  parameter int unsigned MODE_W = fbdiv_pkg::FB_MODE_W,
  parameter int unsigned BASE_P = fbdiv_pkg::FB_BASE_P,
  localparam int unsigned MAX_P = fbdiv_pkg::fb_max_p(BASE_P, MODE_W),
  localparam int unsigned CNT_W = $clog2(MAX_P + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [A_W-1:0]    swallow_i,
  input  logic [B_W-1:0]    main_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              pulse_o,
  output logic              cfg_err_o
);
  logic              fresh_q, fresh_d;
  logic              pulse_q, pulse_d;
  logic              run_en, tick, cyc_end;
  logic              a_zero, a_one, b_zero, b_one;
  logic [A_W-1:0]    a_val;
  logic [B_W-1:0]    b_val;
  logic [MODE_W-1:0] mode_sh;
  logic [CNT_W-1:0]  pre_cnt;

  // Setting check on live inputs; a bad setting freezes and rearms the cycle.
  assign cfg_err_o = (main_i == '0) || (B_W'(swallow_i) > main_i);
  assign run_en    = !cfg_err_o;

  fbdiv_prescaler #(.MODE_W(MODE_W), .BASE_P(BASE_P)) u_pre (
    .clk_i, .rst_ni,
    .en_i(run_en), .restart_i(fresh_q), .mode_ld_i(mode_i),
    .plus_one_i(!a_zero), .tick_o(tick), .mode_o(mode_sh), .cnt_o(pre_cnt)
  );

  fbdiv_downcnt #(.W(A_W)) u_swallow (
    .clk_i, .rst_ni,
    .en_i(run_en), .restart_i(fresh_q), .load_i(swallow_i), .dec_i(tick),
    .is_zero_o(a_zero), .is_one_o(a_one), .value_o(a_val)
  );

  fbdiv_downcnt #(.W(B_W)) u_main (
    .clk_i, .rst_ni,
    .en_i(run_en), .restart_i(fresh_q), .load_i(main_i), .dec_i(tick),
    .is_zero_o(b_zero), .is_one_o(b_one), .value_o(b_val)
  );

  always_comb begin
    cyc_end = tick && b_one;
    fresh_d = cfg_err_o || cyc_end;
    pulse_d = run_en && cyc_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      fresh_q <= fresh_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q && !cfg_err_o;
endmodule

// File: rtl/swallow_fbdiv_checker.sv
module swallow_fbdiv_checker #(
  parameter int unsigned A_W    = 6,
  parameter int unsigned B_W    = 13,
  parameter int unsigned MODE_W = 2,
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned MAX_P  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pulse_o,
  input logic              cfg_err_o,
  input logic              tick,
  input logic              fresh_q,
  input logic [A_W-1:0]    a_val,
  input logic [B_W-1:0]    b_val,
  input logic [MODE_W-1:0] mode_sh,
  input logic [CNT_W-1:0]  pre_cnt
);
  a_r3_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  a_r1_pulse_follows_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(tick));

  a_r1_prescale_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt <= CNT_W'(MAX_P));

  a_r6_swallow_within_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fresh_q |-> (B_W'(a_val) <= b_val));

  a_r8_error_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> fresh_q);

  a_r9_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fresh_q |=> $stable(mode_sh));
endmodule

bind swallow_fbdiv swallow_fbdiv_checker #(
  .A_W(A_W), .B_W(B_W), .MODE_W(MODE_W), .CNT_W(CNT_W), .MAX_P(MAX_P)
) u_chk (
  .clk_i, .rst_ni, .pulse_o, .cfg_err_o, .tick, .fresh_q,
  .a_val, .b_val, .mode_sh, .pre_cnt
);

// File: tb/swallow_fbdiv_test.sv
module swallow_fbdiv_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [5:0]  swallow_i;
  logic [12:0] main_i;
  logic [1:0]  mode_i;
  logic        pulse_o, cfg_err_o;
  int          tests = 0;
  int          fails = 0;

  always #10 clk_i = ~clk_i;

  swallow_fbdiv uut (.clk_i, .rst_ni, .swallow_i, .main_i, .mode_i, .pulse_o, .cfg_err_o);

  function automatic int exp_n(int a, int b, int m);
    return b * (8 << m) + a;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(int a, int b, int m);
    swallow_i = 6'(a);
    main_i    = 13'(b);
    mode_i    = 2'(m);
  endtask

  task automatic wait_pulse(output int c);
    c = 0;
    forever begin
      @(negedge clk_i);
      c++;
      if (pulse_o) break;
    end
  endtask

  // Called at a negedge where pulse_o is high: next edge starts a new cycle.
  task automatic run_gap(int a, int b, int m, string tag);
    int c;
    apply(a, b, m);
    wait_pulse(c);
    chk(c == exp_n(a, b, m), tag, c, exp_n(a, b, m));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c, n;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0;
    apply(5, 10, 1);
    repeat (3) @(negedge clk_i);
    chk(pulse_o == 1'b0, "R10 pulse low in reset", pulse_o, 0);
    chk(cfg_err_o == 1'b0, "R7 valid setting no error", cfg_err_o, 0);

    rst_ni = 1'b1;
    wait_pulse(c);
    chk(c == exp_n(5, 10, 1), "R4 first pulse after reset", c, exp_n(5, 10, 1));
    @(negedge clk_i);
    chk(pulse_o == 1'b0, "R3 single clock pulse", pulse_o, 0);
    wait_pulse(c);
    chk(c + 1 == exp_n(5, 10, 1), "R1 steady period", c + 1, exp_n(5, 10, 1));

    for (int m = 0; m < 4; m++) run_gap(7, 20, m, "R2 mode ratio");
    run_gap(0, 13, 2, "R5 zero swallow");
    run_gap(0, 1, 0, "R5 zero swallow B1");
    run_gap(9, 9, 3, "R6 swallow equals main");
    run_gap(63, 63, 0, "R6 swallow equals main max A");
    run_gap(1, 1, 1, "R6 swallow equals main B1");
    run_gap(63, 8191, 0, "R1 largest main");

    // R9: change setting mid-cycle
    run_gap(2, 5, 0, "R1 before change");
    repeat (10) @(negedge clk_i);
    apply(3, 4, 1);
    wait_pulse(c);
    chk(c + 10 == exp_n(2, 5, 0), "R9 old cycle kept", c + 10, exp_n(2, 5, 0));
    wait_pulse(c);
    chk(c == exp_n(3, 4, 1), "R9 new setting next cycle", c, exp_n(3, 4, 1));

    for (int i = 0; i < 20; i++) begin
      int m, b, a, amax;
      m    = int'($urandom % 4);
      b    = int'($urandom % (1500 / (8 << m))) + 1;
      amax = (b < 63) ? b : 63;
      a    = int'($urandom % (amax + 1));
      run_gap(a, b, m, "R1 random setting");
    end

    // R7 / R8: invalid settings
    apply(5, 3, 0);
    #1;
    chk(cfg_err_o == 1'b1, "R7 main below swallow", cfg_err_o, 1);
    n = 0;
    repeat (300) begin
      @(negedge clk_i);
      if (pulse_o) n++;
    end
    chk(n == 0, "R7 no pulse while error", n, 0);
    apply(0, 0, 1);
    #1;
    chk(cfg_err_o == 1'b1, "R7 main zero", cfg_err_o, 1);
    @(negedge clk_i);
    apply(4, 6, 1);
    #1;
    chk(cfg_err_o == 1'b0, "R7 error clears", cfg_err_o, 0);
    wait_pulse(c);
    chk(c == exp_n(4, 6, 1), "R8 restart after error", c, exp_n(4, 6, 1));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule